// File: doc/BRIEF.md
# PHY Management Control Register

This block is the main control word of a 100 Mb/s half-duplex Ethernet PHY, reached through a plain register port. The port carries an address, a write strobe, 16-bit write data and combinational read data. Four writable fields drive the loopback, power-down, isolate and collision-test controls. A self-clearing bit starts a timed internal reset pulse. The capability fields are hardwired: speed reads as 100 Mb/s, while auto-negotiation, restart and full duplex read as off. Writes to those fields are ignored.

With collision test on, the block also closes the loop from transmit enable to the collision output. COL follows TXEN one management cycle later, and a 40 ns cycle meets both the assert bound and the deassert bound. Power-down holds this loop idle. The pulse length is a cycle count, so a 6-cycle pulse at 40 ns gives the 240 ns reset.

Top module: `phy_ctrl_reg`

## Requirements
- R1: A write to the register address with bit 15 set, while no pulse is running, raises `int_rst_o` from the next cycle for exactly RST_PULSE_CYC cycles.
- R2: Read bit 15 is 1 while the pulse runs and 0 otherwise. While the pulse runs, every write to the register is ignored, and a second bit-15 write does not lengthen the pulse.
- R3: Read bit 13 (speed) is always 1, even after a write of 0 to it.
- R4: Read bits 12, 9, 8 and 6..0 are always 0, even after writes of 1 to them.
- R5: Bit 14 is read/write and drives `loopback_o`.
- R6: Bit 11 is read/write and drives `pwrdn_o`. Bit 10 is read/write and drives `isolate_o`.
- R7: When bit 7 is 1 and bit 11 is 0, in this cycle and in the previous one, `col_o` equals `txen_i` from one cycle earlier. Otherwise `col_o` is 0.
- R8: Both the hardware reset and the start of the pulse clear bits 14, 11, 10 and 7 to 0, and these bits stay 0 while the pulse runs.
- R9: A read of any address other than REG_ADDR returns 0. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Management clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| txen_i | input | 1 | Transmit enable from the MAC side |
| col_o | output | 1 | Collision indication produced by the test loop |
| int_rst_o | output | 1 | Internal reset pulse |
| loopback_o | output | 1 | Loopback enable |
| pwrdn_o | output | 1 | Power-down request |
| isolate_o | output | 1 | MII isolate request |

## Verification
The bench builds the block with RST_PULSE_CYC = 4 and REG_ADDR = 3. The short pulse lets the test run both the full pulse and writes that land inside it, including a second reset request, in a few cycles. The non-zero address shows that decoding follows the parameter and not a fixed zero, and it makes address 0 a miss address for the R9 checks. A behavioural model built from queue-free integer state is compared with every output on every cycle, across TXEN toggle patterns, power-down masking and a hardware reset in mid-run.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;
  localparam int unsigned REG_W = 16;
  // bit positions software decodes
  localparam int unsigned B_RST   = 15;
  localparam int unsigned B_LOOP  = 14;
  localparam int unsigned B_SPEED = 13;
  localparam int unsigned B_PWRDN = 11;
  localparam int unsigned B_ISO   = 10;
  localparam int unsigned B_COLT  = 7;

  typedef struct packed {
    logic loop;
    logic pwrdn;
    logic iso;
    logic colt;
  } ctrl_t;
endpackage

// File: rtl/phy_ctrl_pulse.sv
module phy_ctrl_pulse #(
  parameter int unsigned LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && cnt_q == '0) cnt_q <= CW'(LEN);
    else if (cnt_q != '0)           cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  // width checker: index of the current busy cycle
  logic [CW-1:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  // R1
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  // R1
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> run_q < CW'(LEN));
  // R2
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(run_q) == CW'(LEN - 1));
endmodule

// File: rtl/phy_ctrl_fields.sv
module phy_ctrl_fields
  import phy_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  logic  clr_i,
  input  ctrl_t wval_i,
  output ctrl_t ctrl_o
);
  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= '0;
    else if (clr_i) ctrl_q <= '0;
    else if (wr_i)  ctrl_q <= wval_i;
  end

  assign ctrl_o = ctrl_q;

  // R8
  fields_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ctrl_o == '0);
  // R5
  fields_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/phy_ctrl_col.sv
module phy_ctrl_col (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic txen_i,
  output logic col_o
);
  logic col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= 1'b0;
    else         col_q <= en_i & txen_i;
  end

  assign col_o = col_q & en_i;

  // R7
  col_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && $past(en_i) |-> col_o == $past(txen_i));
  // R7
  col_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !col_o);
endmodule

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned REG_ADDR      = 0,
  parameter int unsigned RST_PULSE_CYC = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              txen_i,
  output logic              col_o,
  output logic              int_rst_o,
  output logic              loopback_o,
  output logic              pwrdn_o,
  output logic              isolate_o
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

  logic  hit, wr_hit, busy, start;
  ctrl_t wval, ctrl;

  assign hit    = (addr_i == SEL);
  assign wr_hit = we_i & hit & ~busy;
  assign start  = wr_hit & wdata_i[B_RST];

  assign wval.loop  = wdata_i[B_LOOP];
  assign wval.pwrdn = wdata_i[B_PWRDN];
  assign wval.iso   = wdata_i[B_ISO];
  assign wval.colt  = wdata_i[B_COLT];

  phy_ctrl_pulse #(.LEN(RST_PULSE_CYC)) i_pulse (
    .clk_i, .rst_ni, .start_i(start), .busy_o(busy)
  );

  phy_ctrl_fields i_fields (
    .clk_i, .rst_ni, .wr_i(wr_hit), .clr_i(start | busy),
    .wval_i(wval), .ctrl_o(ctrl)
  );

  phy_ctrl_col i_col (
    .clk_i, .rst_ni, .en_i(ctrl.colt & ~ctrl.pwrdn),
    .txen_i, .col_o
  );

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[B_RST]   = busy;
      rdata_o[B_LOOP]  = ctrl.loop;
      rdata_o[B_SPEED] = 1'b1;
      rdata_o[B_PWRDN] = ctrl.pwrdn;
      rdata_o[B_ISO]   = ctrl.iso;
      rdata_o[B_COLT]  = ctrl.colt;
    end
  end

  assign int_rst_o  = busy;
  assign loopback_o = ctrl.loop;
  assign pwrdn_o    = ctrl.pwrdn;
  assign isolate_o  = ctrl.iso;

  // R8
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> !(loopback_o | pwrdn_o | isolate_o));
  // R3
  speed_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> rdata_o[B_SPEED]);
  // R4
  fixed_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6:0] == '0 && !rdata_o[12] && !rdata_o[9] && !rdata_o[8]);
  // R9
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> rdata_o == '0);
  // R2
  busy_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o && we_i |=> $stable(loopback_o) && $stable(pwrdn_o) && $stable(isolate_o));
endmodule

// File: tb/test_phy_ctrl_reg.sv
module test_phy_ctrl_reg;
  localparam int ADDR_W = 5;
  localparam int A      = 3;
  localparam int P      = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic we = 1'b0, txen = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic col, int_rst, lb, pd, iso;

  always #4 clk = ~clk;

  phy_ctrl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(A), .RST_PULSE_CYC(P)) i_phy_ctrl_reg (
    .clk_i(clk), .rst_ni, .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .txen_i(txen), .col_o(col), .int_rst_o(int_rst),
    .loopback_o(lb), .pwrdn_o(pd), .isolate_o(iso)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string req = "R3";

  // reference state
  bit m_lb, m_pd, m_iso, m_ct, m_colq;
  int m_cnt;

  task automatic mreset();
    m_lb = 0; m_pd = 0; m_iso = 0; m_ct = 0; m_colq = 0; m_cnt = 0;
  endtask

  task automatic chk(string r, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] e;
    bit en;
    e = '0;
    if (addr == ADDR_W'(A)) begin
      e[15] = (m_cnt > 0); e[14] = m_lb; e[13] = 1'b1;
      e[11] = m_pd; e[10] = m_iso; e[7] = m_ct;
    end
    en = m_ct & ~m_pd;
    chk(req, "rdata", rdata, e);
    chk("R1", "int_rst", {15'd0, int_rst}, {15'd0, m_cnt > 0});
    chk("R5", "loopback", {15'd0, lb}, {15'd0, m_lb});
    chk("R6", "pwrdn", {15'd0, pd}, {15'd0, m_pd});
    chk("R6", "isolate", {15'd0, iso}, {15'd0, m_iso});
    chk("R7", "col", {15'd0, col}, {15'd0, m_colq & en});
  endtask

  task automatic mstep();
    bit busy, en;
    busy = (m_cnt > 0);
    en = m_ct & ~m_pd;
    m_colq = txen & en;
    if (we && addr == ADDR_W'(A) && !busy) begin
      if (wdata[15]) begin
        m_cnt = P; m_lb = 0; m_pd = 0; m_iso = 0; m_ct = 0;
      end else begin
        m_lb = wdata[14]; m_pd = wdata[11]; m_iso = wdata[10]; m_ct = wdata[7];
      end
    end else if (busy) m_cnt--;
  endtask

  // called at a negedge: drive, check, clock, model
  task automatic cyc(int a, bit w, logic [15:0] d, bit t);
    addr = ADDR_W'(a); we = w; wdata = d; txen = t;
    #1 compare();
    @(posedge clk);
    mstep();
    @(negedge clk);
  endtask

  initial begin
    mreset();
    #10 @(negedge clk);
    req = "R4"; cyc(A, 0, 0, 0);            // reset state
    rst_ni = 1'b1;
    req = "R9"; cyc(0, 0, 0, 0);
    req = "R3"; cyc(A, 1, 16'h0000, 0);     // speed stays 1 after writing 0
    req = "R4"; cyc(A, 1, 16'h7FFF, 0);     // fixed zeros after all-ones
    cyc(A, 0, 0, 0);
    req = "R5"; cyc(A, 1, 16'h4000, 0); cyc(A, 0, 0, 0);
    req = "R6"; cyc(A, 1, 16'h0C00, 0); cyc(A, 0, 0, 0);
    cyc(A, 1, 16'h0400, 0); cyc(A, 0, 0, 0);
    // collision loop, toggling patterns
    req = "R7"; cyc(A, 1, 16'h0080, 1);
    for (int i = 0; i < 24; i++) cyc(A, 0, 0, bit'((i % 3) == 0 || (i % 5) == 1));
    cyc(A, 0, 0, 1); cyc(A, 0, 0, 1); cyc(A, 0, 0, 0); cyc(A, 0, 0, 1);
    // power-down masks the loop
    cyc(A, 1, 16'h0880, 1);
    for (int i = 0; i < 6; i++) cyc(A, 0, 0, bit'(i & 1));
    cyc(A, 1, 16'h0080, 1); cyc(A, 0, 0, 1); cyc(A, 0, 0, 0);
    // other address ignored
    req = "R9"; cyc(0, 1, 16'hCC80, 1); cyc(7, 1, 16'h0000, 0); cyc(A, 0, 0, 0);
    // reset pulse
    req = "R8"; cyc(A, 1, 16'h4C80, 0);
    req = "R1"; cyc(A, 1, 16'hCC80, 1);
    req = "R2"; cyc(A, 1, 16'h4C80, 1); cyc(A, 1, 16'h8000, 0);
    for (int i = 0; i < P + 2; i++) cyc(A, 0, 0, 1);
    req = "R2"; cyc(A, 1, 16'h4400, 0); cyc(A, 0, 0, 0);
    // hardware reset mid-run
    req = "R8"; cyc(A, 1, 16'h4C80, 1); cyc(A, 0, 0, 1);
    rst_ni = 1'b0; mreset();
    #1 compare();
    @(negedge clk); rst_ni = 1'b1;
    cyc(A, 0, 0, 0); cyc(2, 0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule